// File: doc/BRIEF.md
# Snooping Write-Through Invalidate Cache Controller

A small direct-mapped cache controller for one processor. Several copies share one atomic broadcast bus. Each line holds one word, a tag and a single valid bit, so a line is either Valid or Invalid. A block that is not resident counts as Invalid.

Loads that hit are answered locally. Loads that miss fetch the word over the bus and allocate it. Every store is written through to memory over the bus. A store updates a resident copy but never allocates. A snooping port watches every bus transaction. When another controller writes a block this cache holds, the local copy is dropped.

The processor side is a valid/ready stream:
- A request is taken when `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` stays low from that point until the response has been taken, so only one operation is ever outstanding.
- The response is offered on `cpu_rsp_valid`. It is held, with stable data, until `cpu_rsp_ready` accepts it.

The bus side works as follows:
- The controller raises `bus_req` and keeps command, address and write data steady.
- A transaction finishes in the cycle where `bus_gnt` and `bus_ack` are both high. Read data is sampled in that cycle.

Top module: `swti_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `bus_req` and `bus_cmd` are 0.
- R2: A load whose line is Valid with a matching tag returns the cached word with no bus transaction. The response is visible two clock edges after acceptance.
- R3: A load to an Invalid or non-matching line issues one bus read (`bus_cmd`=1) of the word address. It returns `bus_rdata` and installs the line as Valid, so a repeat load hits.
- R4: Every store issues exactly one bus write (`bus_cmd`=2) carrying the address and data. Its response returns the stored data. `bus_cmd` is 0 whenever `bus_req` is low.
- R5: A store to a Valid matching line updates the cached word. A later load hits and returns the new word.
- R6: A store to an Invalid or non-matching line does not allocate. A later load to it misses and reads memory.
- R7: A snooped bus write from another controller (`snp_src` differs from `MY_ID`) whose address matches a Valid line makes that line Invalid.
- R8: Snooped transactions whose `snp_src` equals `MY_ID` change no line state.
- R9: A snooped bus read (`snp_cmd`=1) from another controller changes no line state.
- R10: A snooped write with the same index but a different tag leaves the resident line Valid.
- R11: A snoop invalidation that lands in the same cycle as a load's tag lookup wins. The load is treated as a miss and fetched from memory.
- R12: While an operation is outstanding, `cpu_req_ready` is 0. A response not accepted stays valid with unchanged data.
- R13: Once raised, `bus_req` holds with stable command and address until the cycle with `bus_gnt` and `bus_ack` both high.
- Address split: the low log2(LINES) bits of a word address are the index; the remaining bits are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request offered |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Response offered |
| cpu_rsp_ready | input | 1 | Processor takes response |
| cpu_rsp_rdata | output | DATA_W | Load data, or stored data for a store |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus granted |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 write |
| bus_addr | output | ADDR_W | Transaction word address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Transaction completes (with grant) |
| bus_rdata | input | DATA_W | Read data from memory |
| snp_valid | input | 1 | A bus transaction is visible to snoopers |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_src | input | ID_W | Originator of the snooped transaction |

## Verification
The bound checker watches the handshake rules on every cycle: a held bus request with a frozen command and address, a held response with frozen data, no new acceptance while busy, and an idle command whenever no request is raised. Line-state behaviour cannot be seen from a single cycle. That covers hits without bus traffic, no allocation on store misses, invalidation by foreign writes, and the exemptions for own, read and different-tag snoops. The bench shows these through load sequences checked against its behavioural model, including a snoop placed exactly in the lookup cycle.

// File: rtl/swti_pkg.sv
package swti_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_BUS,
    ST_RSP
  } ctl_state_e;
endpackage

// File: rtl/swti_line_store.sv
module swti_line_store #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              snp_hit,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic [LINES-1:0] vld;
  logic [TAG_W-1:0]  tag_a  [LINES];
  logic [DATA_W-1:0] data_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic kill, load;

    assign kill = inv_en && (inv_idx == IDX_W'(g));
    assign load = wr_en && (wr_idx == IDX_W'(g));

    // Invalidation from the snoop side overrides a same-cycle fill.
    always_ff @(posedge clk) begin
      if (!rst_n)    v_q <= 1'b0;
      else if (kill) v_q <= 1'b0;
      else if (load) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (load && !kill) begin
        t_q <= wr_tag;
        d_q <= wr_data;
      end
    end

    assign vld[g]    = v_q;
    assign tag_a[g]  = t_q;
    assign data_a[g] = d_q;
  end

  assign look_hit  = vld[look_idx] && (tag_a[look_idx] == look_tag);
  assign look_data = data_a[look_idx];
  assign snp_hit   = vld[snp_idx] && (tag_a[snp_idx] == snp_tag);
endmodule

// File: rtl/swti_snoop_filter.sv
module swti_snoop_filter
  import swti_pkg::*;
#(
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic            snp_valid,
  input  logic [1:0]      snp_cmd,
  input  logic [ID_W-1:0] snp_src,
  input  logic            snp_hit,
  output logic            snp_kill
);
  logic foreign, is_write;

  assign foreign  = snp_src != ID_W'(MY_ID);
  assign is_write = snp_cmd == CMD_WRITE;
  assign snp_kill = snp_valid && is_write && foreign && snp_hit;
endmodule

// File: rtl/swti_ctrl.sv
module swti_ctrl
  import swti_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] op_addr,
  input  logic              hit,
  input  logic [DATA_W-1:0] hit_data,
  output logic              fill_en,
  output logic [DATA_W-1:0] fill_data
);
  ctl_state_e        st_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rsp_q;
  logic              done;

  assign done = (st_q == ST_BUS) && bus_gnt && bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          we_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          st_q    <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!we_q && hit) begin
            rsp_q <= hit_data;
            st_q  <= ST_RSP;
          end else begin
            st_q <= ST_BUS;
          end
        end
        ST_BUS: if (done) begin
          rsp_q <= we_q ? wdata_q : bus_rdata;
          st_q  <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = st_q == ST_IDLE;
  assign rsp_valid = st_q == ST_RSP;
  assign rsp_rdata = rsp_q;
  assign bus_req   = st_q == ST_BUS;
  assign bus_cmd   = !bus_req ? CMD_IDLE : (we_q ? CMD_WRITE : CMD_READ);
  assign bus_addr  = bus_req ? addr_q : '0;
  assign bus_wdata = (bus_req && we_q) ? wdata_q : '0;
  assign op_addr   = addr_q;

  // Read completion installs the line; write completion only refreshes a resident copy.
  assign fill_en   = done && (!we_q || hit);
  assign fill_data = we_q ? wdata_q : bus_rdata;
endmodule

// File: rtl/swti_cache.sv
module swti_cache
  import swti_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_src
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] op_addr;
  logic [IDX_W-1:0]  op_idx, sn_idx;
  logic [TAG_W-1:0]  op_tag, sn_tag;
  logic              look_hit, snp_hit, snp_kill, hit_eff, fill_en;
  logic [DATA_W-1:0] look_data, fill_data;

  assign op_idx = op_addr[IDX_W-1:0];
  assign op_tag = op_addr[ADDR_W-1:IDX_W];
  assign sn_idx = snp_addr[IDX_W-1:0];
  assign sn_tag = snp_addr[ADDR_W-1:IDX_W];

  // A same-cycle invalidation of the looked-up line turns the hit into a miss.
  assign hit_eff = look_hit && !(snp_kill && (sn_idx == op_idx));

  swti_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .look_idx(op_idx), .look_tag(op_tag), .look_hit(look_hit), .look_data(look_data),
    .snp_idx(sn_idx), .snp_tag(sn_tag), .snp_hit(snp_hit),
    .wr_en(fill_en), .wr_idx(op_idx), .wr_tag(op_tag), .wr_data(fill_data),
    .inv_en(snp_kill), .inv_idx(sn_idx)
  );

  swti_snoop_filter #(.ID_W(ID_W), .MY_ID(MY_ID)) u_filter (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_src(snp_src),
    .snp_hit(snp_hit), .snp_kill(snp_kill)
  );

  swti_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready), .req_write(cpu_req_write),
    .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata),
    .rsp_valid(cpu_rsp_valid), .rsp_ready(cpu_rsp_ready), .rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .op_addr(op_addr), .hit(hit_eff), .hit_data(look_data),
    .fill_en(fill_en), .fill_data(fill_data)
  );
endmodule

// File: rtl/swti_cache_chk.sv
module swti_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_ack,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr
);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(bus_gnt && bus_ack) |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

  assert_cmd_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_cmd == 2'd1 || bus_cmd == 2'd2));

  assert_cmd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> bus_cmd == 2'd0);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata));

  assert_busy_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !cpu_rsp_valid && !bus_req);

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);
endmodule

bind swti_cache swti_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_swti_cache.sv
module tb_swti_cache;
  localparam int AW = 12, DW = 32, LINES = 8, IDW = 2, MYID = 0, OTHER = 2;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cpu_req_valid = 0, cpu_req_write = 0, cpu_rsp_ready = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid, bus_req;
  logic [DW-1:0] cpu_rsp_rdata, bus_wdata;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic gnt = 0, ack = 0;
  logic [DW-1:0] rdata = '0;
  logic ext_v = 0;
  logic [1:0] ext_cmd = 0;
  logic [AW-1:0] ext_addr = '0;
  logic [IDW-1:0] ext_src = '0;
  logic snp_valid;
  logic [1:0] snp_cmd;
  logic [AW-1:0] snp_addr;
  logic [IDW-1:0] snp_src;

  // Own transactions are echoed to the snoop port in their completing cycle.
  assign snp_valid = (gnt && ack) || ext_v;
  assign snp_cmd   = (gnt && ack) ? bus_cmd : ext_cmd;
  assign snp_addr  = (gnt && ack) ? bus_addr : ext_addr;
  assign snp_src   = (gnt && ack) ? IDW'(MYID) : ext_src;

  swti_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(LINES), .ID_W(IDW), .MY_ID(MYID)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(ack), .bus_rdata(rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src));

  int tests = 0, fails = 0;
  logic [DW-1:0] mem [int];
  bit mv [LINES];
  int mt [LINES];
  logic [DW-1:0] md [LINES];
  int nbus = 0;
  logic [1:0] last_cmd;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_wdata;
  bit busy = 0;
  logic [1:0] exp_cmd = 0;
  logic [AW-1:0] exp_addr = '0;
  int gnt_wait = 0, gcnt = 0;

  function automatic logic [DW-1:0] memrd(logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {20'hA5C3E, a} ^ 32'h1357_0000;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bus responder and memory
  always @(negedge clk) begin
    if (gnt && ack) begin gnt <= 0; ack <= 0; end
    else if (gnt) begin ack <= 1; rdata <= memrd(bus_addr); end
    else if (bus_req) begin
      if (gcnt >= gnt_wait) begin gnt <= 1; gcnt <= 0; end
      else gcnt <= gcnt + 1;
    end
  end

  always @(posedge clk) if (gnt && ack) begin
    nbus++;
    last_cmd = bus_cmd; last_addr = bus_addr; last_wdata = bus_wdata;
    if (bus_cmd == 2'd2) mem[int'(bus_addr)] = bus_wdata;
  end

  // Per-cycle comparison against the model (R12, R13, R4)
  always @(negedge clk) if (rst_n) begin
    check(cpu_req_ready == !busy, "R12", "ready vs outstanding", cpu_req_ready, !busy);
    if (bus_req) begin
      check(bus_cmd == exp_cmd, "R13", "bus_cmd while requesting", bus_cmd, exp_cmd);
      check(bus_addr == exp_addr, "R13", "bus_addr while requesting", bus_addr, exp_addr);
    end else
      check(bus_cmd == 2'd0, "R4", "idle bus_cmd", bus_cmd, 0);
  end

  task automatic cpu_op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, int hold, string req,
                        bit snoop_in_look = 0, logic [DW-1:0] snp_data = '0);
    int idx = int'(a) % LINES, tg = int'(a) / LINES, lat = 0, b0;
    bit hit;
    logic [DW-1:0] exp;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = we; cpu_req_addr = a; cpu_req_wdata = wd;
    exp_cmd = we ? 2'd2 : 2'd1; exp_addr = a; b0 = nbus;
    @(posedge clk); busy = 1;
    @(negedge clk); cpu_req_valid = 0; lat = 1;
    if (snoop_in_look) begin
      // R11: foreign write to the same block during the lookup cycle
      ext_v = 1; ext_cmd = 2'd2; ext_addr = a; ext_src = IDW'(OTHER);
      mem[int'(a)] = snp_data;
      if (mv[idx] && mt[idx] == tg) mv[idx] = 0;
      @(posedge clk); #1 ext_v = 0;
    end
    hit = mv[idx] && mt[idx] == tg;
    while (!cpu_rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    if (we) begin
      exp = wd;
      if (hit) md[idx] = wd;
    end else if (hit) exp = md[idx];
    else begin
      exp = memrd(a);
      mv[idx] = 1; mt[idx] = tg; md[idx] = exp;
    end
    check(cpu_rsp_rdata == exp, req, "response data", cpu_rsp_rdata, exp);
    if (!we && hit) begin
      check(nbus == b0, req, "bus transactions on hit", nbus - b0, 0);
      check(lat == 2, req, "hit latency", lat, 2);
    end else begin
      check(nbus == b0 + 1, req, "bus transaction count", nbus - b0, 1);
      check(last_cmd == exp_cmd && last_addr == a, req, "bus cmd/addr",
            {last_cmd, last_addr}, {exp_cmd, a});
      if (we) check(last_wdata == wd, req, "bus write data", last_wdata, wd);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(cpu_rsp_valid && cpu_rsp_rdata == exp, "R12", "held response", cpu_rsp_rdata, exp);
    end
    cpu_rsp_ready = 1;
    @(posedge clk); busy = 0;
    #1 cpu_rsp_ready = 0;
  endtask

  task automatic ext_snoop(logic [1:0] cmd, logic [AW-1:0] a, int src, logic [DW-1:0] d);
    int idx = int'(a) % LINES, tg = int'(a) / LINES;
    @(negedge clk);
    ext_v = 1; ext_cmd = cmd; ext_addr = a; ext_src = IDW'(src);
    if (cmd == 2'd2 && src != MYID) begin
      mem[int'(a)] = d;
      if (mv[idx] && mt[idx] == tg) mv[idx] = 0;
    end
    @(posedge clk); #1 ext_v = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] r = 16'hACE1;
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = 0; md[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(cpu_req_ready && !cpu_rsp_valid && !bus_req && bus_cmd == 0, "R1", "reset outputs",
          {cpu_req_ready, cpu_rsp_valid, bus_req, bus_cmd}, 5'b10000);

    cpu_op(0, 12'h010, 0, 0, "R3");             // cold miss
    cpu_op(0, 12'h010, 0, 0, "R2");             // hit
    cpu_op(1, 12'h010, 32'hDEAD_0001, 0, "R5"); // write hit
    cpu_op(0, 12'h010, 0, 0, "R5");             // sees new data locally
    cpu_op(1, 12'h023, 32'hBEEF_0002, 0, "R6"); // write miss, no allocate
    cpu_op(0, 12'h023, 0, 0, "R6");             // must miss
    cpu_op(0, 12'h041, 0, 0, "R3");
    ext_snoop(2'd2, 12'h041, OTHER, 32'h7777_0041);
    cpu_op(0, 12'h041, 0, 0, "R7");             // invalidated: miss, fresh data
    cpu_op(0, 12'h052, 0, 0, "R3");
    ext_snoop(2'd2, 12'h052, MYID, 32'h0);
    cpu_op(0, 12'h052, 0, 0, "R8");             // own id ignored: hit
    ext_snoop(2'd1, 12'h052, OTHER, 32'h0);
    cpu_op(0, 12'h052, 0, 0, "R9");             // foreign read: hit
    ext_snoop(2'd2, 12'h0F2, OTHER, 32'h5555_00F2);
    cpu_op(0, 12'h052, 0, 0, "R10");            // other tag: hit
    cpu_op(0, 12'h052, 0, 0, "R11", 1, 32'h1111_0052);
    cpu_op(0, 12'h052, 0, 3, "R12");            // back-pressure on response
    gnt_wait = 4;
    cpu_op(1, 12'h052, 32'hCAFE_0052, 0, "R13");
    cpu_op(0, 12'h066, 0, 2, "R13");
    gnt_wait = 1;
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      a = AW'(12'h100 + ((r >> 3) & 3) * LINES + (r & 7));
      if (r[10:9] == 2'b11) ext_snoop(2'd2, a, OTHER, {r, ~r});
      cpu_op(r[8], a, {~r, r}, int'(r[12]), r[8] ? "R4" : "R3");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule